// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder-Subtractor

This block adds or subtracts two IEEE-754 binary32 operands and delivers the rounded result one clock after the operands are presented. A subtract request flips the sign of the second operand ahead of a shared add path. A 2-bit rounding mode picks one of the four directed roundings. Subnormal operands and subnormal results are handled exactly, without flushing to zero.

Each result carries four flags: invalid, overflow, underflow and inexact. They describe only the operation that produced that result. Gathering them into a sticky status word is up to the caller. A NaN-handling select chooses between two schemes. The standard scheme quiets NaNs, prefers the second operand's NaN and raises invalid for a signalling NaN. The legacy scheme returns a NaN operand bit for bit and raises no flag.

Top module: `fp_addsub`

## Requirements
- R1: After reset `outValid`, `result` and all flags are 0. When `inValid` is high at a rising edge, `outValid` is high after that edge and `result` and the flags hold that operation's outcome.
- R2: Finite addition is rounded to the `roundMode` encoding 0 = nearest-even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. Inexact is raised exactly when the rounded value differs from the exact sum. Example: 0x3fc00000 + 0x34400000 gives 0x3fc00002 / 0x3fc00001 / 0x3fc00002 / 0x3fc00001 with only inexact.
- R3: With `subOp` = 1 the result equals `opA` + (`opB` with its sign bit inverted). An exact zero sum of operands with opposite effective signs is +0, except in mode 3, where it is -0.
- R4: Subnormal inputs and outputs are exact. 0x00800001 - 0x00800000 = 0x00000001 with no flags.
- R5: When the rounded magnitude exceeds the largest finite value, overflow and inexact are raised. The result is infinity in mode 0 and when rounding toward the result's sign. Otherwise it is the largest finite value (0x7f7fffff, with the result's sign).
- R6: Underflow is raised only when the result is tiny and also inexact. A sum of subnormals is always exact, so it raises no underflow.
- R7: A finite value plus an infinity gives that infinity with no flag. Infinities with opposite effective signs give the default NaN 0x7fc00000 with invalid, in both NaN schemes.
- R8: With `nanLegacy` = 0 and a NaN operand, the result is `opB`'s NaN if `opB` is a NaN, else `opA`'s. In either case mantissa bit 22 (the quiet bit) is forced to 1. Invalid is raised exactly when either operand is a signalling NaN (quiet bit 0).
- R9: With `nanLegacy` = 1 and a NaN operand, the result is `opA` if it is a NaN, else `opB`, returned unchanged even when signalling, and no flag is raised.
- R10: A quiet NaN with a non-NaN partner comes out unchanged with no flags in both schemes. `subOp` never alters a NaN's sign bit.
- R11: When `inValid` is low at a rising edge, `outValid` is low after it and `result` and the flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opA | input | 32 | First operand, binary32 |
| opB | input | 32 | Second operand, binary32 |
| subOp | input | 1 | 1 = subtract `opB` from `opA` |
| roundMode | input | 2 | Rounding mode, encoding as in R2 |
| nanLegacy | input | 1 | 0 = standard NaN scheme, 1 = legacy NaN scheme |
| outValid | output | 1 | Result and flags are from the previous cycle's operation |
| result | output | 32 | Rounded result, binary32 |
| flagInvalid | output | 1 | Invalid operation |
| flagOverflow | output | 1 | Overflow |
| flagUnderflow | output | 1 | Underflow (tiny and inexact) |
| flagInexact | output | 1 | Result was rounded |

## Verification
The bench builds the block with its default format parameters, an 8-bit exponent and a 23-bit mantissa, so every vector is a literal binary32 bit pattern. That choice puts in reach the exact halfway and sticky roundings just below one unit in the last place, both overflow edges of the largest finite value, the transition from subnormal to normal, and signalling and quiet NaN payloads at the quiet-bit position. Each rounding case runs in all four modes, and each NaN case runs in both schemes.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } roundMode_e;

  // Strobes from the special-case control to the datapath
  typedef struct packed {
    logic selNan;        // result is a NaN taken from an operand
    logic selNanB;       // that NaN is opB (else opA)
    logic quietNan;      // force the quiet bit on the passed NaN
    logic selDefNan;     // result is the default NaN
    logic selInf;        // result is an infinity
    logic infSign;       // sign of that infinity
    logic raiseInvalid;  // invalid flag for this operation
  } fpStrobes_t;

endpackage

// File: rtl/fp_addsub_ctrl.sv
module fp_addsub_ctrl
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 subOp,
  input  logic                 nanLegacy,
  output fpStrobes_t           strobes
);

  localparam int MSB = EXP_W + MAN_W;

  logic aExpOnes, bExpOnes, aManNz, bManNz;
  logic aNan, bNan, aSnan, bSnan, aInf, bInf;
  logic signA, signBEff, anyNan, infClash;

  always_comb begin
    aExpOnes = &opA[MSB-1:MAN_W];
    bExpOnes = &opB[MSB-1:MAN_W];
    aManNz   = |opA[MAN_W-1:0];
    bManNz   = |opB[MAN_W-1:0];
    aNan     = aExpOnes & aManNz;
    bNan     = bExpOnes & bManNz;
    aSnan    = aNan & ~opA[MAN_W-1];
    bSnan    = bNan & ~opB[MAN_W-1];
    aInf     = aExpOnes & ~aManNz;
    bInf     = bExpOnes & ~bManNz;
    signA    = opA[MSB];
    signBEff = opB[MSB] ^ subOp;
    anyNan   = aNan | bNan;
    infClash = ~anyNan & aInf & bInf & (signA != signBEff);

    strobes.selNan       = anyNan;
    strobes.selNanB      = nanLegacy ? ~aNan : bNan;
    strobes.quietNan     = ~nanLegacy;
    strobes.selDefNan    = infClash;
    strobes.selInf       = ~anyNan & ~infClash & (aInf | bInf);
    strobes.infSign      = aInf ? signA : signBEff;
    strobes.raiseInvalid = infClash | (~nanLegacy & (aSnan | bSnan));
  end

endmodule

// File: rtl/fp_addsub_dp.sv
module fp_addsub_dp
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 subOp,
  input  logic [1:0]           roundMode,
  input  fpStrobes_t           strobes,
  output logic                 outValid,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 flagInvalid,
  output logic                 flagOverflow,
  output logic                 flagUnderflow,
  output logic                 flagInexact
);

  localparam int MSB   = EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;        // significand with hidden bit
  localparam int SW    = SIG_W + 3;        // plus guard, round, sticky
  localparam int EXT_W = EXP_W + 2;        // exponent with headroom
  localparam int LZ_W  = $clog2(SW + 1);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXT_W-1:0] EXP_LIMIT = EXT_W'(EXP_ONES);

  function automatic logic [LZ_W-1:0] leadZeros(input logic [SW-1:0] v);
    leadZeros = LZ_W'(SW);
    for (int i = 0; i < SW; i++) begin
      if (v[i]) leadZeros = LZ_W'(SW - 1 - i);
    end
  endfunction

  logic                 signA, signB, aBig, signBig, signSmall, opSubEff;
  logic [EXT_W-1:0]     eA, eB, eBig, eSmall, eDiff, maxShift, shAmt, eNrm, expRnd;
  logic [SIG_W-1:0]     sigA, sigB;
  logic [SW-1:0]        bigExt, smallExt, smallAl, lostMask, nrm;
  logic [SW:0]          sumRaw;
  logic [LZ_W-1:0]      lz;
  logic                 lsbBit, grdBit, stkBit, incBit, exactZero, tiny, inexact;
  logic                 overflow, toInf, zeroSign;
  logic [SIG_W:0]       rnd;
  logic [MSB:0]         nextResult, nanSrc;
  logic                 nextInv, nextOvf, nextUnf, nextInx;

  // Operand unpack and alignment
  always_comb begin
    signA = opA[MSB];
    signB = opB[MSB] ^ subOp;
    eA    = (opA[MSB-1:MAN_W] == '0) ? EXT_W'(1) : EXT_W'(opA[MSB-1:MAN_W]);
    eB    = (opB[MSB-1:MAN_W] == '0) ? EXT_W'(1) : EXT_W'(opB[MSB-1:MAN_W]);
    sigA  = {|opA[MSB-1:MAN_W], opA[MAN_W-1:0]};
    sigB  = {|opB[MSB-1:MAN_W], opB[MAN_W-1:0]};
    aBig  = opA[MSB-1:0] >= opB[MSB-1:0];

    signBig   = aBig ? signA : signB;
    signSmall = aBig ? signB : signA;
    eBig      = aBig ? eA : eB;
    eSmall    = aBig ? eB : eA;
    bigExt    = {(aBig ? sigA : sigB), 3'b000};
    smallExt  = {(aBig ? sigB : sigA), 3'b000};
    eDiff     = eBig - eSmall;

    if (eDiff >= EXT_W'(SW)) begin
      smallAl  = '0;
      lostMask = '1;
    end else begin
      smallAl  = smallExt >> eDiff;
      lostMask = ~({SW{1'b1}} << eDiff);
    end
    smallAl[0] = smallAl[0] | (|(smallExt & lostMask));

    opSubEff = signBig ^ signSmall;
    sumRaw   = opSubEff ? ({1'b0, bigExt} - {1'b0, smallAl})
                        : ({1'b0, bigExt} + {1'b0, smallAl});
    exactZero = (sumRaw == '0);
  end

  // Normalisation, clamped at the minimum exponent for subnormals
  always_comb begin
    lz       = leadZeros(sumRaw[SW-1:0]);
    maxShift = eBig - EXT_W'(1);
    if (sumRaw[SW]) begin
      nrm   = {sumRaw[SW:2], |sumRaw[1:0]};
      eNrm  = eBig + EXT_W'(1);
      shAmt = '0;
    end else begin
      shAmt = (EXT_W'(lz) < maxShift) ? EXT_W'(lz) : maxShift;
      nrm   = sumRaw[SW-1:0] << shAmt;
      eNrm  = eBig - shAmt;
    end
  end

  // Rounding
  always_comb begin
    lsbBit  = nrm[3];
    grdBit  = nrm[2];
    stkBit  = |nrm[1:0];
    inexact = grdBit | stkBit;
    tiny    = ~nrm[SW-1];
    case (roundMode_e'(roundMode))
      RM_NEAR: incBit = grdBit & (stkBit | lsbBit);
      RM_ZERO: incBit = 1'b0;
      RM_UP:   incBit = inexact & ~signBig;
      default: incBit = inexact & signBig;
    endcase
    rnd    = {1'b0, nrm[SW-1:3]} + (SIG_W+1)'(incBit);
    expRnd = rnd[SIG_W] ? (eNrm + EXT_W'(1)) : (rnd[SIG_W-1] ? eNrm : '0);
    overflow = (expRnd >= EXP_LIMIT);
    toInf    = (roundMode_e'(roundMode) == RM_NEAR) |
               ((roundMode_e'(roundMode) == RM_UP) & ~signBig) |
               ((roundMode_e'(roundMode) == RM_DOWN) & signBig);
    zeroSign = opSubEff ? (roundMode_e'(roundMode) == RM_DOWN) : signBig;
  end

  // Result selection
  always_comb begin
    nanSrc  = strobes.selNanB ? opB : opA;
    nextInv = strobes.raiseInvalid;
    nextOvf = 1'b0;
    nextUnf = 1'b0;
    nextInx = 1'b0;
    if (strobes.selDefNan) begin
      nextResult = {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};
    end else if (strobes.selNan) begin
      nextResult = nanSrc;
      if (strobes.quietNan) nextResult[MAN_W-1] = 1'b1;
    end else if (strobes.selInf) begin
      nextResult = {strobes.infSign, EXP_ONES, {MAN_W{1'b0}}};
    end else if (exactZero) begin
      nextResult = {zeroSign, {(MSB){1'b0}}};
    end else if (overflow) begin
      nextOvf = 1'b1;
      nextInx = 1'b1;
      nextResult = toInf ? {signBig, EXP_ONES, {MAN_W{1'b0}}}
                         : {signBig, EXP_ONES - EXP_W'(1), {MAN_W{1'b1}}};
    end else begin
      nextInx    = inexact;
      nextUnf    = tiny & inexact;
      nextResult = {signBig, expRnd[EXP_W-1:0], rnd[MAN_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      result        <= '0;
      flagInvalid   <= 1'b0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInexact   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result        <= nextResult;
        flagInvalid   <= nextInv;
        flagOverflow  <= nextOvf;
        flagUnderflow <= nextUnf;
        flagInexact   <= nextInx;
      end
    end
  end

endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fp_addsub_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  logic                 subOp,
  input  logic [1:0]           roundMode,
  input  logic                 nanLegacy,
  output logic                 outValid,
  output logic [EXP_W+MAN_W:0] result,
  output logic                 flagInvalid,
  output logic                 flagOverflow,
  output logic                 flagUnderflow,
  output logic                 flagInexact
);

  fpStrobes_t strobes;

  fp_addsub_ctrl #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ctrl (
    .opA       (opA),
    .opB       (opB),
    .subOp     (subOp),
    .nanLegacy (nanLegacy),
    .strobes   (strobes)
  );

  fp_addsub_dp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .opA           (opA),
    .opB           (opB),
    .subOp         (subOp),
    .roundMode     (roundMode),
    .strobes       (strobes),
    .outValid      (outValid),
    .result        (result),
    .flagInvalid   (flagInvalid),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact)
  );

endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [EXP_W+MAN_W:0] opA,
  input logic                 nanLegacy,
  input logic                 outValid,
  input logic [EXP_W+MAN_W:0] result,
  input logic                 flagInvalid,
  input logic                 flagOverflow,
  input logic                 flagUnderflow,
  input logic                 flagInexact
);

  localparam int MSB = EXP_W + MAN_W;

  logic aIsNan, resQuietNan;
  assign aIsNan      = (&opA[MSB-1:MAN_W]) & (|opA[MAN_W-1:0]);
  assign resQuietNan = (&result[MSB-1:MAN_W]) & result[MAN_W-1];

  // R1: a presented operation is answered one cycle later
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R11: idle cycle produces no valid and holds the outputs
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(flagInvalid) &&
                  $stable(flagOverflow) && $stable(flagUnderflow) &&
                  $stable(flagInexact)));

  // R5: overflow always comes with inexact
  p_ovf_inexact_r5: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> flagInexact);

  // R6: underflow only when inexact
  p_unf_inexact_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> flagInexact);

  // R8: an invalid operation always yields a quiet NaN
  p_invalid_qnan_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> resQuietNan);

  // R9: legacy scheme returns the first operand's NaN untouched
  p_legacy_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && nanLegacy && aIsNan) |=>
      (result == $past(opA) && !flagInvalid && !flagInexact));

endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .opA           (opA),
  .nanLegacy     (nanLegacy),
  .outValid      (outValid),
  .result        (result),
  .flagInvalid   (flagInvalid),
  .flagOverflow  (flagOverflow),
  .flagUnderflow (flagUnderflow),
  .flagInexact   (flagInexact)
);

// File: tb/fp_addsub_tb.sv
module fp_addsub_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 51;

  // {opA, opB, sub, rm, legacy, expected, flags{V,O,U,I}, requirement}
  localparam logic [111:0] VECS [NV] = '{
    {32'h3fc00000, 32'h34400000, 1'b0, 2'd0, 1'b0, 32'h3fc00002, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34400000, 1'b0, 2'd1, 1'b0, 32'h3fc00001, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34400000, 1'b0, 2'd2, 1'b0, 32'h3fc00002, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34400000, 1'b0, 2'd3, 1'b0, 32'h3fc00001, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34a00000, 1'b0, 2'd0, 1'b0, 32'h3fc00002, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34a00000, 1'b0, 2'd1, 1'b0, 32'h3fc00002, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34a00000, 1'b0, 2'd2, 1'b0, 32'h3fc00003, 4'h1, 8'd2}, // R2
    {32'h3fc00000, 32'h34a00000, 1'b0, 2'd3, 1'b0, 32'h3fc00002, 4'h1, 8'd2}, // R2
    {32'h3f800000, 32'h3f800000, 1'b0, 2'd0, 1'b0, 32'h40000000, 4'h0, 8'd2}, // R2
    {32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'd0, 1'b0, 32'h7f800000, 4'h5, 8'd5}, // R5
    {32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'd1, 1'b0, 32'h7f7fffff, 4'h5, 8'd5}, // R5
    {32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'd2, 1'b0, 32'h7f800000, 4'h5, 8'd5}, // R5
    {32'h7f7fffff, 32'h7f7fffff, 1'b0, 2'd3, 1'b0, 32'h7f7fffff, 4'h5, 8'd5}, // R5
    {32'hff7fffff, 32'hff7fffff, 1'b0, 2'd0, 1'b0, 32'hff800000, 4'h5, 8'd5}, // R5
    {32'hff7fffff, 32'hff7fffff, 1'b0, 2'd1, 1'b0, 32'hff7fffff, 4'h5, 8'd5}, // R5
    {32'hff7fffff, 32'hff7fffff, 1'b0, 2'd2, 1'b0, 32'hff7fffff, 4'h5, 8'd5}, // R5
    {32'hff7fffff, 32'hff7fffff, 1'b0, 2'd3, 1'b0, 32'hff800000, 4'h5, 8'd5}, // R5
    {32'h3f800001, 32'h33800000, 1'b1, 2'd0, 1'b0, 32'h3f800000, 4'h1, 8'd3}, // R3
    {32'h3f800001, 32'h33800000, 1'b1, 2'd1, 1'b0, 32'h3f800000, 4'h1, 8'd3}, // R3
    {32'h3f800001, 32'h33800000, 1'b1, 2'd2, 1'b0, 32'h3f800001, 4'h1, 8'd3}, // R3
    {32'h3f800001, 32'h33800000, 1'b1, 2'd3, 1'b0, 32'h3f800000, 4'h1, 8'd3}, // R3
    {32'h3f800002, 32'h33800000, 1'b1, 2'd0, 1'b0, 32'h3f800002, 4'h1, 8'd3}, // R3
    {32'h3f800002, 32'h33800000, 1'b1, 2'd1, 1'b0, 32'h3f800001, 4'h1, 8'd3}, // R3
    {32'h3f800002, 32'h33800000, 1'b1, 2'd2, 1'b0, 32'h3f800002, 4'h1, 8'd3}, // R3
    {32'h3f800002, 32'h33800000, 1'b1, 2'd3, 1'b0, 32'h3f800001, 4'h1, 8'd3}, // R3
    {32'hbf800000, 32'h3f800000, 1'b1, 2'd0, 1'b0, 32'hc0000000, 4'h0, 8'd3}, // R3
    {32'h3f800000, 32'h3f800000, 1'b1, 2'd0, 1'b0, 32'h00000000, 4'h0, 8'd3}, // R3
    {32'h3f800000, 32'h3f800000, 1'b1, 2'd3, 1'b0, 32'h80000000, 4'h0, 8'd3}, // R3
    {32'h3f800000, 32'hbf800000, 1'b0, 2'd2, 1'b0, 32'h00000000, 4'h0, 8'd3}, // R3
    {32'h00800001, 32'h00800000, 1'b1, 2'd0, 1'b0, 32'h00000001, 4'h0, 8'd4}, // R4
    {32'h00400000, 32'h00400000, 1'b0, 2'd0, 1'b0, 32'h00800000, 4'h0, 8'd4}, // R4
    {32'h80000003, 32'h00000001, 1'b0, 2'd1, 1'b0, 32'h80000002, 4'h0, 8'd4}, // R4
    {32'h00000001, 32'h00000001, 1'b0, 2'd2, 1'b0, 32'h00000002, 4'h0, 8'd6}, // R6
    {32'h3fc00000, 32'h7f800000, 1'b0, 2'd0, 1'b0, 32'h7f800000, 4'h0, 8'd7}, // R7
    {32'h7f800000, 32'hff800000, 1'b0, 2'd0, 1'b0, 32'h7fc00000, 4'h8, 8'd7}, // R7
    {32'h7f800000, 32'hff800000, 1'b0, 2'd0, 1'b1, 32'h7fc00000, 4'h8, 8'd7}, // R7
    {32'h7f800000, 32'h7f800000, 1'b1, 2'd1, 1'b0, 32'h7fc00000, 4'h8, 8'd7}, // R7
    {32'h3f800000, 32'h7f800000, 1'b1, 2'd0, 1'b0, 32'hff800000, 4'h0, 8'd7}, // R7
    {32'h3fc00000, 32'h7fc00001, 1'b0, 2'd0, 1'b0, 32'h7fc00001, 4'h0, 8'd10}, // R10
    {32'h3fc00000, 32'h7f800001, 1'b0, 2'd0, 1'b0, 32'h7fc00001, 4'h8, 8'd8}, // R8
    {32'h7f800001, 32'h7fbfffff, 1'b0, 2'd0, 1'b0, 32'h7fffffff, 4'h8, 8'd8}, // R8
    {32'h7fbfffff, 32'h7f800001, 1'b0, 2'd0, 1'b0, 32'h7fc00001, 4'h8, 8'd8}, // R8
    {32'h7fc00001, 32'h7fbfffff, 1'b0, 2'd0, 1'b0, 32'h7fffffff, 4'h8, 8'd8}, // R8
    {32'h7fbfffff, 32'h7fc00001, 1'b0, 2'd0, 1'b0, 32'h7fc00001, 4'h8, 8'd8}, // R8
    {32'h3fc00000, 32'h7fc00001, 1'b0, 2'd0, 1'b1, 32'h7fc00001, 4'h0, 8'd10}, // R10
    {32'h3fc00000, 32'h7f800001, 1'b0, 2'd0, 1'b1, 32'h7f800001, 4'h0, 8'd9}, // R9
    {32'h7f800001, 32'h7fbfffff, 1'b0, 2'd0, 1'b1, 32'h7f800001, 4'h0, 8'd9}, // R9
    {32'h7fbfffff, 32'h7f800001, 1'b0, 2'd0, 1'b1, 32'h7fbfffff, 4'h0, 8'd9}, // R9
    {32'h7fc00001, 32'h7fbfffff, 1'b0, 2'd0, 1'b1, 32'h7fc00001, 4'h0, 8'd9}, // R9
    {32'h7fbfffff, 32'h7fc00001, 1'b0, 2'd0, 1'b1, 32'h7fbfffff, 4'h0, 8'd9}, // R9
    {32'h3f800000, 32'h7fc00001, 1'b1, 2'd0, 1'b0, 32'h7fc00001, 4'h0, 8'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subOp = 1'b0;
  logic [1:0]  roundMode = '0;
  logic        nanLegacy = 1'b0;
  logic        outValid;
  logic [31:0] result;
  logic        flagInvalid, flagOverflow, flagUnderflow, flagInexact;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_addsub u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .opA           (opA),
    .opB           (opB),
    .subOp         (subOp),
    .roundMode     (roundMode),
    .nanLegacy     (nanLegacy),
    .outValid      (outValid),
    .result        (result),
    .flagInvalid   (flagInvalid),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInexact   (flagInexact)
  );

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", {35'd0, outValid}, 36'd0);
    check("R1 reset result/flags",
          {result, flagInvalid, flagOverflow, flagUnderflow, flagInexact}, 36'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [111:0] v;
      v = VECS[i];
      opA       = v[111:80];
      opB       = v[79:48];
      subOp     = v[47];
      roundMode = v[46:45];
      nanLegacy = v[44];
      inValid   = 1'b1;
      @(negedge clk);
      check($sformatf("R1 valid vec %0d", i), {35'd0, outValid}, 36'd1);
      check($sformatf("R%0d vec %0d", v[7:0], i),
            {result, flagInvalid, flagOverflow, flagUnderflow, flagInexact},
            {v[43:12], v[11:8]});
    end

    // R11: idle cycle keeps previous outcome (last vector: 0x7fc00001, no flags)
    inValid = 1'b0;
    opA = 32'h40000000;
    opB = 32'h40000000;
    @(negedge clk);
    check("R11 idle valid", {35'd0, outValid}, 36'd0);
    check("R11 idle hold",
          {result, flagInvalid, flagOverflow, flagUnderflow, flagInexact},
          {32'h7fc00001, 4'h0});

    // R1: new operation after idle, flags from this op only (sticky not kept)
    inValid = 1'b1;
    opA = 32'h7f800000; opB = 32'hff800000; subOp = 1'b0; nanLegacy = 1'b0;
    @(negedge clk);
    opA = 32'h3f800000; opB = 32'h3f800000; roundMode = 2'd0;
    @(negedge clk);
    check("R1 flags per op",
          {result, flagInvalid, flagOverflow, flagUnderflow, flagInexact},
          {32'h40000000, 4'h0});
    inValid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule